// File: doc/BRIEF.md
# Latched Masked Interrupt Controller

This block sits between a set of interrupt sources and a processor core. Every source has a latch bit that captures an event whether or not the source is currently enabled, so no event is lost while software has it masked. A separate enable mask decides which latched events may be raised towards the core. Among eligible events a fixed priority picks one: the lowest bit index wins.

The core and the block exchange two strobes. An accept strobe moves the chosen event from the latch register into the in-service register. A return strobe retires the most urgent level still in service. Because the in-service register can hold several bits at once, nested service is tracked. A new request is raised only if it outranks every level already in service. A global disable bit in a control register silences all requests and leaves the latched events untouched.

Software reaches four registers through a simple write strobe and a combinational read port: latch (write-one-to-clear), mask, in-service (read-only) and control.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the latch, mask, in-service and control registers read zero and `int_req` is low.
- R2: A high level on `irq_src[i]` during a clock edge sets latch bit i at that edge, whatever the mask bit i holds.
- R3: `int_req` is high exactly when some bit is set in both latch and mask, the disable bit is clear and the lowest such index outranks every in-service bit; `int_id` then gives that lowest index.
- R4: `int_ack` while `int_req` is high clears latch bit `int_id` and sets in-service bit `int_id` at the same edge; `int_ack` while `int_req` is low changes nothing.
- R5: `int_rti` clears the lowest-index set bit of the in-service register and no other bit.
- R6: While level p is in service, a latched, unmasked source with index below p raises a request that can be accepted, giving two in-service bits; a source with index above p raises none.
- R7: Writing the latch register (address 0) clears each latch bit whose write-data bit is 1; a source event in the same cycle keeps its bit set.
- R8: The mask register (address 1) is written and read back as stored, bit i enabling source i.
- R9: The in-service register (address 2) is read-only; writes to it leave it unchanged.
- R10: Control register (address 3) bit 0 is the global disable: when 1 `int_req` stays low and latch bits are kept; the upper bits read zero.
- R11: `reg_rdata` shows the register chosen by `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_SRC | Source events, one bit each, sampled every edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 latch, 1 mask, 2 in-service, 3 control |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| int_req | output | 1 | Interrupt request towards the core |
| int_id | output | ID_W | Index of the requested source |
| int_ack | input | 1 | Accept strobe from the core |
| int_rti | input | 1 | Return-from-interrupt strobe from the core |

## Verification
The hardest state to reach from the ports is a nested service: one level must be accepted and held in service while a more urgent source is latched, unmasked, raised and accepted on top of it, and lower-priority events must sit latched without being raised. The directed stimulus builds this up in order — latch several sources, accept the most urgent, inject a still more urgent event, accept again — and then retires levels one return strobe at a time, reading the in-service register back after each step to confirm which level was dropped and which request reappears.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_SERV  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  // A candidate wins over the in-service set if nothing is in service
  // or its index is strictly lower than the most urgent serviced level.
  function automatic logic outranks(input int unsigned cand_idx,
                                    input logic serv_any,
                                    input int unsigned serv_idx);
    return !serv_any || (cand_idx < serv_idx);
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
    onehot = hit ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] take_oh,
  output logic [N-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~sw_clr & ~take_oh) | src;
  end
endmodule

// File: rtl/irq_serv_track.sv
module irq_serv_track #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_oh,
  input  logic [N-1:0] clr_oh,
  output logic [N-1:0] serv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serv_q <= '0;
    else        serv_q <= (serv_q & ~clr_oh) | set_oh;
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               int_req,
  output logic [ID_W-1:0]    int_id,
  input  logic               int_ack,
  input  logic               int_rti
);
  import irq_latch_pkg::*;

  logic [NUM_SRC-1:0] latch_q, mask_q, serv_q;
  logic               dis_q;
  logic [NUM_SRC-1:0] cand_vec, cand_oh, serv_oh;
  logic               cand_hit, serv_hit;
  logic [ID_W-1:0]    cand_idx, serv_idx;
  logic               accept_fire, rti_fire;
  logic [NUM_SRC-1:0] accept_oh, rti_oh, sw_clr;
  reg_sel_e           sel;

  assign sel      = reg_sel_e'(reg_addr);
  assign cand_vec = latch_q & mask_q;

  irq_prio_enc #(.N(NUM_SRC), .IW(ID_W)) u_cand_enc (
    .vec(cand_vec), .hit(cand_hit), .idx(cand_idx), .onehot(cand_oh));

  irq_prio_enc #(.N(NUM_SRC), .IW(ID_W)) u_serv_enc (
    .vec(serv_q), .hit(serv_hit), .idx(serv_idx), .onehot(serv_oh));

  assign int_req = cand_hit && !dis_q &&
                   outranks(int'(cand_idx), serv_hit, int'(serv_idx));
  assign int_id  = cand_idx;

  assign accept_fire = int_ack && int_req;
  assign rti_fire    = int_rti && serv_hit;
  assign accept_oh   = accept_fire ? cand_oh : '0;
  assign rti_oh      = rti_fire ? serv_oh : '0;
  assign sw_clr      = (reg_wr && sel == SEL_LATCH) ? reg_wdata : '0;

  irq_latch_bank #(.N(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .sw_clr(sw_clr),
    .take_oh(accept_oh), .latch_q(latch_q));

  irq_serv_track #(.N(NUM_SRC)) u_serv (
    .clk(clk), .rst_n(rst_n), .set_oh(accept_oh), .clr_oh(rti_oh),
    .serv_q(serv_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dis_q  <= 1'b0;
    end else if (reg_wr) begin
      if (sel == SEL_MASK) mask_q <= reg_wdata;
      if (sel == SEL_CTRL) dis_q  <= reg_wdata[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LATCH: reg_rdata = latch_q;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_SERV:  reg_rdata = serv_q;
      default:   reg_rdata = {{(NUM_SRC-1){1'b0}}, dis_q};
    endcase
  end
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int N = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_src,
  input logic [N-1:0]  latch_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  serv_q,
  input logic          dis_q,
  input logic          serv_hit,
  input logic [IW-1:0] serv_idx,
  input logic          int_req,
  input logic [IW-1:0] int_id,
  input logic          accept_fire,
  input logic          rti_fire,
  input logic          reg_wr,
  input logic [1:0]    reg_addr
);
  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src != '0) |=> ((latch_q & $past(irq_src)) == $past(irq_src))); // R2
  AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (latch_q[int_id] && mask_q[int_id])); // R3
  AST_ACCEPT_SETS_SERV: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> serv_q[$past(int_id)]); // R4
  AST_ACCEPT_TAKES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fire && !irq_src[int_id]) |=> !latch_q[$past(int_id)]); // R4
  AST_RTI_DROPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_fire && !accept_fire) |=> !serv_q[$past(serv_idx)]); // R5
  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && serv_hit) |-> (int_id < serv_idx)); // R6
  AST_SERV_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !accept_fire && !rti_fire) |=> $stable(serv_q)); // R9
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !int_req); // R10
endmodule

bind irq_latch_ctrl irq_latch_chk #(.N(NUM_SRC), .IW(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .latch_q(latch_q),
  .mask_q(mask_q), .serv_q(serv_q), .dis_q(dis_q), .serv_hit(serv_hit),
  .serv_idx(serv_idx), .int_req(int_req), .int_id(int_id),
  .accept_fire(accept_fire), .rti_fire(rti_fire), .reg_wr(reg_wr),
  .reg_addr(reg_addr));

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_src = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          int_req;
  logic [IW-1:0] int_id;
  logic          int_ack = 1'b0;
  logic          int_rti = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_req(int_req), .int_id(int_id), .int_ack(int_ack), .int_rti(int_rti));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all drivers change at the falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic event_on(input logic [N-1:0] v);
    irq_src = v;
    cycle();
    irq_src = '0;
  endtask

  task automatic ack();
    int_ack = 1'b1; cycle(); int_ack = 1'b0;
  endtask

  task automatic rti();
    int_rti = 1'b1; cycle(); int_rti = 1'b0;
  endtask

  task automatic chk_req(input string tag, input logic r, input int id);
    #1 check({tag, " req"}, 32'(int_req), 32'(r));
    if (r) check({tag, " id"}, 32'(int_id), 32'(id));
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1/R11 reset reg", 32'(d), 0);
    end
    chk_req("R1 reset", 1'b0, 0);
  endtask

  task automatic t_latch_masked();
    logic [N-1:0] d;
    event_on(16'h0020);
    rd(2'd0, d); check("R2 latched while masked", 32'(d), 32'h0020);
    chk_req("R3 masked no req", 1'b0, 0);
    wr(2'd1, 16'h0020);
    rd(2'd1, d); check("R8 mask readback", 32'(d), 32'h0020);
    chk_req("R3 unmasked", 1'b1, 5);
    wr(2'd1, 16'hFFFF);
    event_on(16'h0208);
    chk_req("R3 lowest index wins", 1'b1, 3);
  endtask

  task automatic t_nesting();
    logic [N-1:0] d;
    ack();
    rd(2'd0, d); check("R4 latch bit taken", 32'(d), 32'h0220);
    rd(2'd2, d); check("R4 serv bit set", 32'(d), 32'h0008);
    chk_req("R6 lower prio blocked", 1'b0, 0);
    event_on(16'h0002);
    chk_req("R6 higher prio preempts", 1'b1, 1);
    ack();
    rd(2'd2, d); check("R6 nested serv", 32'(d), 32'h000A);
    rti();
    rd(2'd2, d); check("R5 rti drops level 1", 32'(d), 32'h0008);
    chk_req("R6 still blocked", 1'b0, 0);
    rti();
    rd(2'd2, d); check("R5 rti drops level 3", 32'(d), 32'h0000);
    chk_req("R3 next request", 1'b1, 5);
  endtask

  task automatic t_ack_ignored();
    logic [N-1:0] d;
    wr(2'd1, 16'h0000);
    ack();
    rd(2'd0, d); check("R4 stray ack latch", 32'(d), 32'h0220);
    rd(2'd2, d); check("R4 stray ack serv", 32'(d), 32'h0000);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_w1c();
    logic [N-1:0] d;
    wr(2'd0, 16'h0020);
    rd(2'd0, d); check("R7 w1c clears", 32'(d), 32'h0200);
    irq_src = 16'h0200;
    wr(2'd0, 16'h0200);
    irq_src = '0;
    rd(2'd0, d); check("R7 event beats clear", 32'(d), 32'h0200);
  endtask

  task automatic t_serv_ro();
    logic [N-1:0] d;
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); check("R9 serv write ignored", 32'(d), 32'h0000);
    chk_req("R9 req unaffected", 1'b1, 9);
  endtask

  task automatic t_disable();
    logic [N-1:0] d;
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); check("R10 ctrl readback", 32'(d), 32'h0001);
    chk_req("R10 disabled", 1'b0, 0);
    event_on(16'h0004);
    ack();
    rd(2'd0, d); check("R10 latch kept", 32'(d), 32'h0204);
    rd(2'd2, d); check("R10 no accept", 32'(d), 32'h0000);
    wr(2'd3, 16'h0000);
    chk_req("R10 reenabled", 1'b1, 2);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_masked();
    t_nesting();
    t_ack_ignored();
    t_w1c();
    t_serv_ro();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule